// File: doc/BRIEF.md
# Chunky to Planar Converter

This block turns a group of 32 packed 8-bit pixels into bitplane words. Pixels arrive four to a 32-bit word over a valid/ready stream. Once the eighth word of a group has been taken, the whole group is transposed by fixed wiring. The result leaves as one 32-bit word per bitplane, one per cycle, lowest plane first. The final plane word of each group carries a last flag.

A mode input picks full 8-plane output or a reduced 6-plane output. In reduced mode the block still takes all eight input words of a group. It emits only planes 0 to 5. The mode is sampled when a group's first word is accepted.

A capture buffer and a plane buffer are separate, so a new group can load while the previous one drains. The capture side has states CAP_FILL and CAP_HOLD:
- In CAP_FILL, words are accepted. On the last word it goes to CAP_HOLD (transition "group complete, drain busy"), or it stays in CAP_FILL while handing the group straight over.
- In CAP_HOLD, input is blocked until the drain frees up (transition "hand over").

The drain side has states DRN_IDLE and DRN_SEND:
- It goes from DRN_IDLE to DRN_SEND on a load ("group loaded").
- It stays in DRN_SEND on "final plane taken with reload".
- It returns to DRN_IDLE on "final plane taken, nothing pending".

Top module: `c2p_conv`

## Requirements
- R1: After a synchronous reset, out_valid is 0 and in_ready is 1, and both buffers and the plane counter are cleared.
- R2: A group is eight input words. No plane word of a group appears before its eighth word has been accepted, and no plane word appears without a group.
- R3: Pixel i of a group (i = 0..31) is held in input word i/4, at bits [31-8*(i%4) : 24-8*(i%4)], so pixel 0 of each word sits in bits 31..24. Bit 31-i of the plane-k output word equals bit k of pixel i.
- R4: Plane words leave in ascending plane order starting with plane 0. Within a group, each taken plane word is followed in the next cycle by the next one.
- R5: With six_plane = 1 a group yields planes 0..5 only, and with six_plane = 0 it yields planes 0..7. In both modes eight input words are consumed per group.
- R6: The mode is sampled when a group's first word is accepted. Changes of six_plane during the rest of the group have no effect on that group's output.
- R7: out_last is 1 exactly on the final plane word of a group (plane 7, or plane 5 in six-plane mode).
- R8: While out_valid is 1 and out_ready is 0, the next cycle keeps out_valid at 1 and out_data and out_last unchanged.
- R9: With out_ready held at 1, in 8-plane mode in_ready never drops, and whenever plane words are pending out_valid is 1 with no idle cycle.
- R10: When the drain is busy and a new group is complete, in_ready goes low until the group is handed over. No group is lost or overwritten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_word | input | 32 | Four packed pixels, first pixel in the top byte |
| six_plane | input | 1 | 1 selects 6-plane output, sampled on the first word of a group |
| out_valid | output | 1 | Plane word valid |
| out_ready | input | 1 | Downstream takes the plane word |
| out_data | output | 32 | Plane word, bit 31 belongs to pixel 0 |
| out_last | output | 1 | Final plane word of the group |

## Verification
The bench builds the block with its default widths: 32-bit words and 8-bit pixels, so the group is 32 pixels. This size keeps an exhaustive walking-one sweep small. Every one of the 256 single-bit groups (each pixel, each bit) goes through in both modes. That proves each wire of the transpose separately, including the two top planes that the reduced mode drops. A pseudo-random phase follows with sparse ready, gappy valid and a mode input that flips after each first word. It reaches the hold state, the stall hold and the mode-sampling rule.

// File: rtl/c2p_pkg.sv
package c2p_pkg;
    typedef enum logic {
        CAP_FILL,
        CAP_HOLD
    } cap_state_t;

    typedef enum logic {
        DRN_IDLE,
        DRN_SEND
    } drn_state_t;
endpackage

// File: rtl/c2p_capture.sv
module c2p_capture
    import c2p_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int PIX_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [WORD_W-1:0]           in_word,
    input  logic                        six_plane,
    output logic                        in_ready,
    input  logic                        drain_free,
    output logic                        load,
    output logic                        load_six,
    output logic [WORD_W*PIX_W-1:0]     group_flat
);
    localparam int IN_WORDS = PIX_W;
    localparam int TOT      = WORD_W * IN_WORDS;
    localparam int CW       = $clog2(IN_WORDS);
    localparam logic [CW-1:0] LAST_IDX = CW'(IN_WORDS - 1);

    cap_state_t      state_q, state_n;
    logic [CW-1:0]   idx_q;
    logic [TOT-1:0]  buf_q;
    logic            six_q;
    logic            accept;
    logic            complete;

    always_comb begin
        in_ready   = (state_q == CAP_FILL);
        accept     = in_valid && in_ready;
        complete   = accept && (idx_q == LAST_IDX);
        load       = (state_q == CAP_HOLD || complete) && drain_free;
        load_six   = six_q;
        group_flat = (state_q == CAP_HOLD) ? buf_q
                                           : {buf_q[TOT-WORD_W-1:0], in_word};
        state_n    = state_q;
        unique case (state_q)
            CAP_FILL: if (complete && !drain_free) state_n = CAP_HOLD;
            CAP_HOLD: if (drain_free)              state_n = CAP_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CAP_FILL;
            idx_q   <= '0;
            buf_q   <= '0;
            six_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            if (accept) begin
                buf_q <= {buf_q[TOT-WORD_W-1:0], in_word};
                idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + CW'(1);
                if (idx_q == '0) six_q <= six_plane;
            end
        end
    end

    // R10
    hold_until_free_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == CAP_HOLD) && !drain_free |=> (state_q == CAP_HOLD) && $stable(buf_q));
endmodule

// File: rtl/c2p_transpose.sv
module c2p_transpose #(
    parameter int WORD_W = 32,
    parameter int PIX_W  = 8
) (
    input  logic [WORD_W*PIX_W-1:0] group_flat,
    output logic [WORD_W*PIX_W-1:0] planes_flat
);
    localparam int TOT = WORD_W * PIX_W;

    for (genvar k = 0; k < PIX_W; k++) begin : g_plane
        for (genvar i = 0; i < WORD_W; i++) begin : g_pix
            assign planes_flat[k*WORD_W + WORD_W-1-i] = group_flat[TOT - i*PIX_W - PIX_W + k];
        end
    end
endmodule

// File: rtl/c2p_drain.sv
module c2p_drain
    import c2p_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int PIX_W      = 8,
    parameter int RED_PLANES = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic                    load_six,
    input  logic [WORD_W*PIX_W-1:0] planes_flat,
    input  logic                    out_ready,
    output logic                    out_valid,
    output logic [WORD_W-1:0]       out_data,
    output logic                    out_last,
    output logic                    drain_free
);
    localparam int PW = $clog2(PIX_W);
    localparam logic [PW-1:0] FULL_LAST = PW'(PIX_W - 1);
    localparam logic [PW-1:0] RED_LAST  = PW'(RED_PLANES - 1);

    drn_state_t         state_q, state_n;
    logic [WORD_W-1:0]  pl_q [PIX_W];
    logic [PW-1:0]      cnt_q;
    logic               six_q;
    logic               take;

    always_comb begin
        out_valid  = (state_q == DRN_SEND);
        out_data   = pl_q[cnt_q];
        out_last   = out_valid && (cnt_q == (six_q ? RED_LAST : FULL_LAST));
        take       = out_valid && out_ready;
        drain_free = (state_q == DRN_IDLE) || (take && out_last);
        state_n    = state_q;
        unique case (state_q)
            DRN_IDLE: if (load) state_n = DRN_SEND;
            DRN_SEND: if (take && out_last && !load) state_n = DRN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DRN_IDLE;
            cnt_q   <= '0;
            six_q   <= 1'b0;
            for (int k = 0; k < PIX_W; k++) pl_q[k] <= '0;
        end else begin
            state_q <= state_n;
            if (load) begin
                for (int k = 0; k < PIX_W; k++) pl_q[k] <= planes_flat[k*WORD_W +: WORD_W];
                cnt_q <= '0;
                six_q <= load_six;
            end else if (take) begin
                cnt_q <= out_last ? '0 : cnt_q + PW'(1);
            end
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    // R10
    reload_safe_chk: assert property (@(posedge clk) disable iff (rst)
        load && out_valid |-> out_ready && out_last);

    // R4
    plane_stream_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !out_last |=> out_valid && (cnt_q == $past(cnt_q) + PW'(1)));
endmodule

// File: rtl/c2p_conv.sv
module c2p_conv #(
    parameter int WORD_W     = 32,
    parameter int PIX_W      = 8,
    parameter int RED_PLANES = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic              six_plane,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last
);
    localparam int TOT = WORD_W * PIX_W;

    logic           drain_free;
    logic           load;
    logic           load_six;
    logic [TOT-1:0] group_flat;
    logic [TOT-1:0] planes_flat;

    c2p_capture #(.WORD_W(WORD_W), .PIX_W(PIX_W)) u_cap (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_word(in_word), .six_plane(six_plane),
        .in_ready(in_ready), .drain_free(drain_free),
        .load(load), .load_six(load_six), .group_flat(group_flat)
    );

    c2p_transpose #(.WORD_W(WORD_W), .PIX_W(PIX_W)) u_tp (
        .group_flat(group_flat), .planes_flat(planes_flat)
    );

    c2p_drain #(.WORD_W(WORD_W), .PIX_W(PIX_W), .RED_PLANES(RED_PLANES)) u_drn (
        .clk(clk), .rst(rst),
        .load(load), .load_six(load_six), .planes_flat(planes_flat),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .drain_free(drain_free)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid && in_ready);
endmodule

// File: tb/sim_c2p_conv.sv
`timescale 1ns/1ps
module sim_c2p_conv;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_word;
    logic        six_plane;
    logic        out_valid;
    logic        out_ready;
    logic [31:0] out_data;
    logic        out_last;

    always #2 clk = ~clk;

    c2p_conv u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .six_plane(six_plane), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    int vectors = 0;
    int fails   = 0;
    logic [31:0] exp_q[$];
    bit          last_q[$];
    logic [31:0] gw [8];
    bit          gmode;
    logic [31:0] lf = 32'h1234_5678;
    int          blocked;
    bit          prev_stall = 0;
    logic [31:0] prev_data;
    logic        prev_last;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step_lf();
        lf = lf ^ (lf << 13);
        lf = lf ^ (lf >> 17);
        lf = lf ^ (lf << 5);
    endtask

    task automatic make_group(input int ph, input int g);
        for (int w = 0; w < 8; w++) gw[w] = '0;
        if (ph == 3) begin
            for (int w = 0; w < 8; w++) begin
                step_lf();
                gw[w] = lf;
            end
            gmode = (g % 3 == 0);
        end else begin
            gw[(g/8)/4][24 - 8*((g/8)%4) + (g%8)] = 1'b1;
            gmode = (ph == 2);
        end
    endtask

    task automatic push_expected();
        int np;
        logic [31:0] w;
        np = gmode ? 6 : 8;
        for (int k = 0; k < np; k++) begin
            w = '0;
            for (int i = 0; i < 32; i++) w[31-i] = gw[i/4][24 - 8*(i%4) + k];
            exp_q.push_back(w);
            last_q.push_back(k == np-1);
        end
    endtask

    task automatic run_phase(input int ph, input int ng);
        int grp = 0;
        int wi = 0;
        int cyc = 0;
        int qs;
        logic [31:0] e;
        bit el;
        make_group(ph, 0);
        while ((grp < ng || exp_q.size() > 0) && cyc < 60000) begin
            @(negedge clk);
            cyc++;
            if (ph == 3) begin
                step_lf();
                in_valid  = (grp < ng) && lf[3];
                out_ready = lf[7] & lf[9];
            end else begin
                in_valid  = (grp < ng);
                out_ready = 1'b1;
            end
            in_word   = gw[wi];
            six_plane = (wi == 0) ? gmode : ~gmode;
            #1;
            if (prev_stall)
                chk(out_valid && out_data == prev_data && out_last == prev_last,
                    "R8 stalled word changed", out_data, prev_data);
            qs = exp_q.size();
            if (ph != 3) begin
                if (qs > 0) chk(out_valid, "R9 output gap", {31'b0, out_valid}, 32'd1);
                if (ph == 1 && in_valid) chk(in_ready, "R9 input bubble", {31'b0, in_ready}, 32'd1);
            end
            if (in_valid && !in_ready) blocked++;
            if (out_valid && out_ready) begin
                if (qs == 0) begin
                    chk(1'b0, "R2 plane word without complete group", out_data, 32'h0);
                end else begin
                    e  = exp_q.pop_front();
                    el = last_q.pop_front();
                    chk(out_data == e, "R3 R4 R5 R6 plane word", out_data, e);
                    chk(out_last == el, "R7 last flag", {31'b0, out_last}, {31'b0, el});
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            prev_last  = out_last;
            if (in_valid && in_ready) begin
                wi++;
                if (wi == 8) begin
                    push_expected();
                    grp++;
                    wi = 0;
                    if (grp < ng) make_group(ph, grp);
                end
            end
        end
        if (cyc >= 60000) chk(1'b0, "R2 phase stalled", cyc, 0);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        in_word = '0;
        six_plane = 1'b0;
        out_ready = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1 reset state
        chk(!out_valid, "R1 out_valid after reset", {31'b0, out_valid}, 32'd0);
        chk(in_ready, "R1 in_ready after reset", {31'b0, in_ready}, 32'd1);
        run_phase(1, 256);   // 8-plane walking ones, full rate
        run_phase(2, 256);   // 6-plane walking ones (R5)
        blocked = 0;
        run_phase(3, 200);   // random data, backpressure, mode flips (R6, R10)
        chk(blocked > 0, "R10 input never back-pressured", blocked, 1);
        chk(exp_q.size() == 0, "R2 plane words left over", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule